// File: doc/BRIEF.md
# Load/ALUop Interlock Stall Generator

This block decides when a six-stage in-order pipeline (IF, RF, ALU1, MEM, ALU2, WB) has to freeze its front end because a source operand will not exist yet at the point where the consumer needs it, even with forwarding. It looks at two instructions: the producer, which sits in the RF/ALU1 register, and the consumer, which sits in the IF/RF register. A load produces its value at the end of MEM. An ALU operation, either register-register or register-memory, produces its value at the end of ALU2. A consumer needs its address base register at the start of ALU1. A store also needs its data register at the start of MEM. Any operand used later than that is covered by forwarding and never stalls.

When a hazard is found, `hold` freezes the PC and the IF/RF register, and `bubble` turns the RF/ALU1 entry into an invalid slot. Both stay high for one or two cycles. A small down-counter keeps a two-cycle stall going after the producer has moved on. Hazards are only evaluated again once the counter is back at zero.

Top module: `hzd_stall_ctrl`

## Requirements
- R1: While `rst_n` is low, `hold` and `bubble` are low when no hazard is presented, and asserting reset in the middle of a stall ends it at once.
- R2: A valid load producer (class code 2) followed by a valid load (2), store (3), branch (4) or register-memory ALU op (1) whose base register equals the producer's destination stalls for exactly 1 cycle.
- R3: A valid ALU producer (class 0 or 1) followed by a store (3) whose data register equals the destination, with a different base register, stalls for exactly 1 cycle.
- R4: A valid ALU producer (class 0 or 1) followed by a load, store, branch or register-memory ALU op whose base register equals the destination stalls for exactly 2 cycles.
- R5: Dependences that forwarding covers never stall. This includes a load producer followed by a store that uses the loaded register only as store data, and any pair whose registers do not match.
- R6: A register-register ALU consumer (class 0) never causes a stall, whatever its register fields hold.
- R7: A producer that is invalid, a store (3) or a branch (4), or a consumer that is invalid, never causes a stall.
- R8: When a store consumer matches an ALU producer on both its base and its data register, the longer stall (2 cycles) applies.
- R9: `hold` and `bubble` are equal in every cycle. Once a stall has started, input changes do not affect it until its count runs out, and the inputs are then evaluated afresh, so a new stall can begin in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prod_valid | input | 1 | RF/ALU1 slot holds a real instruction |
| prod_class | input | 3 | Producer class: 0 reg-reg ALU, 1 reg-mem ALU, 2 load, 3 store, 4 branch |
| prod_dst | input | REG_W | Producer destination register |
| cons_valid | input | 1 | IF/RF slot holds a real instruction |
| cons_class | input | 3 | Consumer class, same encoding |
| cons_base | input | REG_W | Consumer address base register (read in ALU1) |
| cons_data | input | REG_W | Consumer store data register (read in MEM) |
| hold | output | 1 | Freeze PC and IF/RF |
| bubble | output | 1 | Load an invalid slot into RF/ALU1 |

## Verification
Each producer class is paired with each consumer class. Register matches are placed on the base field alone, on the data field alone, on both, or on neither. These patterns show apart the one-cycle load case, the one-cycle ALU-to-store-data case, the two-cycle ALU-to-base case and the forwarded no-stall cases. Stall length is measured cycle by cycle with the producer replaced by a bubble, as the pipeline would do. A separate run keeps a hazard on the inputs during a stall, which shows that the counter ignores the inputs and then evaluates them again. A reset in the middle of a stall checks that the count is cleared.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [2:0] {
    OP_RR = 3'd0,
    OP_RM = 3'd1,
    OP_LD = 3'd2,
    OP_ST = 3'd3,
    OP_BR = 3'd4
  } op_class_e;
endpackage

// File: rtl/hzd_rst_sync.sv
module hzd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/hzd_detect.sv
module hzd_detect
  import hzd_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int CNT_W = 2,
  parameter int LOAD_BASE_LEN = 1,
  parameter int ALU_DATA_LEN = 1,
  parameter int ALU_BASE_LEN = 2
) (
  input  logic             prod_valid,
  input  op_class_e        prod_cls,
  input  logic [REG_W-1:0] prod_dst,
  input  logic             cons_valid,
  input  op_class_e        cons_cls,
  input  logic [REG_W-1:0] cons_base,
  input  logic [REG_W-1:0] cons_data,
  output logic [CNT_W-1:0] stall_len
);
  logic prod_is_ld, prod_is_alu;
  logic cons_base_rd, cons_data_rd;
  logic base_hit, data_hit;

  always_comb begin
    prod_is_ld   = prod_valid && (prod_cls == OP_LD);
    prod_is_alu  = prod_valid && ((prod_cls == OP_RR) || (prod_cls == OP_RM));
    cons_base_rd = cons_valid && ((cons_cls == OP_LD) || (cons_cls == OP_ST) ||
                                  (cons_cls == OP_BR) || (cons_cls == OP_RM));
    cons_data_rd = cons_valid && (cons_cls == OP_ST);
    base_hit     = cons_base_rd && (cons_base == prod_dst);
    data_hit     = cons_data_rd && (cons_data == prod_dst);

    if (prod_is_alu && base_hit)      stall_len = CNT_W'(ALU_BASE_LEN);
    else if (prod_is_alu && data_hit) stall_len = CNT_W'(ALU_DATA_LEN);
    else if (prod_is_ld && base_hit)  stall_len = CNT_W'(LOAD_BASE_LEN);
    else                              stall_len = '0;
  end
endmodule

// File: rtl/hzd_stall_timer.sv
module hzd_stall_timer #(
  parameter int CNT_W = 2,
  parameter int MAX_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] req_len,
  output logic             stall,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, start;

  always_comb begin
    busy   = (cnt_q != '0);
    start  = !busy && (req_len != '0);
    cnt_en = busy || start;
    cnt_d  = cnt_q;
    if (busy)       cnt_d = cnt_q - 1'b1;
    else if (start) cnt_d = req_len - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign stall = cnt_en;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < MAX_LEN); // R9
  AST_LONG_SUSTAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_len > 1) |=> (busy && stall)); // R4
  AST_SHORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_len == 1) |=> !busy); // R2
endmodule

// File: rtl/hzd_stall_ctrl.sv
module hzd_stall_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W = 5,
  parameter int LOAD_BASE_LEN = 1,
  parameter int ALU_DATA_LEN = 1,
  parameter int ALU_BASE_LEN = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prod_valid,
  input  logic [2:0]       prod_class,
  input  logic [REG_W-1:0] prod_dst,
  input  logic             cons_valid,
  input  logic [2:0]       cons_class,
  input  logic [REG_W-1:0] cons_base,
  input  logic [REG_W-1:0] cons_data,
  output logic             hold,
  output logic             bubble
);
  localparam int MAX_A   = (LOAD_BASE_LEN > ALU_DATA_LEN) ? LOAD_BASE_LEN : ALU_DATA_LEN;
  localparam int MAX_LEN = (ALU_BASE_LEN > MAX_A) ? ALU_BASE_LEN : MAX_A;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             rst_n_i;
  logic [CNT_W-1:0] stall_len;
  logic             stall, busy;
  op_class_e        prod_cls, cons_cls;

  assign prod_cls = op_class_e'(prod_class);
  assign cons_cls = op_class_e'(cons_class);

  hzd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  hzd_detect #(
    .REG_W(REG_W), .CNT_W(CNT_W), .LOAD_BASE_LEN(LOAD_BASE_LEN),
    .ALU_DATA_LEN(ALU_DATA_LEN), .ALU_BASE_LEN(ALU_BASE_LEN)
  ) u_det (
    .prod_valid(prod_valid), .prod_cls(prod_cls), .prod_dst(prod_dst),
    .cons_valid(cons_valid), .cons_cls(cons_cls), .cons_base(cons_base),
    .cons_data(cons_data), .stall_len(stall_len)
  );

  hzd_stall_timer #(.CNT_W(CNT_W), .MAX_LEN(MAX_LEN)) u_tmr (
    .clk(clk), .rst_n(rst_n_i), .req_len(stall_len), .stall(stall), .busy(busy)
  );

  assign hold   = stall;
  assign bubble = stall;

  AST_RR_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!busy && cons_valid && cons_class == 3'd0) |-> !hold); // R6
  AST_NO_PRODUCER: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!busy && (!prod_valid || prod_class == 3'd3 || prod_class == 3'd4)) |-> !hold); // R7
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n_i)
    busy |-> (hold && bubble)); // R9
endmodule

// File: tb/sim_hzd_stall_ctrl.sv
module sim_hzd_stall_ctrl;
  localparam int REG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             prod_valid = 1'b0;
  logic [2:0]       prod_class = 3'd0;
  logic [REG_W-1:0] prod_dst = '0;
  logic             cons_valid = 1'b0;
  logic [2:0]       cons_class = 3'd0;
  logic [REG_W-1:0] cons_base = '0;
  logic [REG_W-1:0] cons_data = '0;
  logic             hold, bubble;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hzd_stall_ctrl #(.REG_W(REG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .prod_valid(prod_valid), .prod_class(prod_class),
    .prod_dst(prod_dst), .cons_valid(cons_valid), .cons_class(cons_class),
    .cons_base(cons_base), .cons_data(cons_data), .hold(hold), .bubble(bubble)
  );

  task automatic chk(string req, logic exp);
    checks++;
    if (hold !== exp || bubble !== exp) begin
      errors++;
      $display("FAIL %s: hold=%b bubble=%b expected %b", req, hold, bubble, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    prod_valid = 1'b0; cons_valid = 1'b0;
  endtask

  // drive a pair, then replace the producer by a bubble, counting stalled cycles
  task automatic run_case(string req, logic [2:0] pc, logic [REG_W-1:0] pd,
                          logic [2:0] cc, logic [REG_W-1:0] cb,
                          logic [REG_W-1:0] cd, int len);
    @(negedge clk);
    prod_valid = 1'b1; prod_class = pc; prod_dst = pd;
    cons_valid = 1'b1; cons_class = cc; cons_base = cb; cons_data = cd;
    #1 chk(req, len > 0);
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      prod_valid = 1'b0;
      #1 chk(req, k < len);
    end
    idle();
  endtask

  task automatic test_reset();
    @(negedge clk);
    #1 chk("R1", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R1", 1'b0);
    // start a 2-cycle stall, then reset in its second cycle
    @(negedge clk);
    prod_valid = 1'b1; prod_class = 3'd0; prod_dst = 5'd7;
    cons_valid = 1'b1; cons_class = 3'd2; cons_base = 5'd7; cons_data = 5'd1;
    #1 chk("R1", 1'b1);
    @(negedge clk);
    prod_valid = 1'b0; cons_valid = 1'b0; rst_n = 1'b0;
    #1 chk("R1", 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R1", 1'b0);
  endtask

  task automatic test_load_base();
    run_case("R2", 3'd2, 5'd5, 3'd2, 5'd5, 5'd9, 1);
    run_case("R2", 3'd2, 5'd5, 3'd3, 5'd5, 5'd9, 1);
    run_case("R2", 3'd2, 5'd12, 3'd4, 5'd12, 5'd3, 1);
    run_case("R2", 3'd2, 5'd31, 3'd1, 5'd31, 5'd0, 1);
  endtask

  task automatic test_alu_data();
    run_case("R3", 3'd0, 5'd6, 3'd3, 5'd2, 5'd6, 1);
    run_case("R3", 3'd1, 5'd20, 3'd3, 5'd21, 5'd20, 1);
  endtask

  task automatic test_alu_base();
    run_case("R4", 3'd0, 5'd4, 3'd2, 5'd4, 5'd8, 2);
    run_case("R4", 3'd1, 5'd9, 3'd4, 5'd9, 5'd1, 2);
    run_case("R4", 3'd0, 5'd3, 3'd1, 5'd3, 5'd0, 2);
    run_case("R4", 3'd1, 5'd17, 3'd3, 5'd17, 5'd2, 2);
  endtask

  task automatic test_forwarded();
    run_case("R5", 3'd2, 5'd5, 3'd3, 5'd1, 5'd5, 0);
    run_case("R5", 3'd0, 5'd5, 3'd2, 5'd6, 5'd5, 0);
    run_case("R5", 3'd2, 5'd5, 3'd4, 5'd6, 5'd5, 0);
  endtask

  task automatic test_rr_consumer();
    run_case("R6", 3'd2, 5'd10, 3'd0, 5'd10, 5'd10, 0);
    run_case("R6", 3'd0, 5'd10, 3'd0, 5'd10, 5'd10, 0);
  endtask

  task automatic test_no_producer();
    run_case("R7", 3'd3, 5'd8, 3'd2, 5'd8, 5'd8, 0);
    run_case("R7", 3'd4, 5'd8, 3'd3, 5'd8, 5'd8, 0);
    @(negedge clk);
    prod_valid = 1'b0; prod_class = 3'd0; prod_dst = 5'd8;
    cons_valid = 1'b1; cons_class = 3'd2; cons_base = 5'd8;
    #1 chk("R7", 1'b0);
    @(negedge clk);
    prod_valid = 1'b1; cons_valid = 1'b0;
    #1 chk("R7", 1'b0);
    idle();
  endtask

  task automatic test_both_hit();
    run_case("R8", 3'd0, 5'd14, 3'd3, 5'd14, 5'd14, 2);
  endtask

  task automatic test_reeval();
    // hazard kept on the inputs: 2-cycle stall, then a fresh one at once
    @(negedge clk);
    prod_valid = 1'b1; prod_class = 3'd0; prod_dst = 5'd11;
    cons_valid = 1'b1; cons_class = 3'd2; cons_base = 5'd11;
    #1 chk("R9", 1'b1);
    @(negedge clk); #1 chk("R9", 1'b1);
    @(negedge clk); #1 chk("R9", 1'b1);
    // hazard removed while the second stall still counts
    @(negedge clk);
    prod_valid = 1'b0;
    #1 chk("R9", 1'b1);
    @(negedge clk); #1 chk("R9", 1'b0);
    idle();
  endtask

  initial begin
    test_reset();
    test_load_base();
    test_alu_data();
    test_alu_base();
    test_forwarded();
    test_rr_consumer();
    test_no_producer();
    test_both_hit();
    test_reeval();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule